// File: doc/BRIEF.md
# Proximity Card Subcarrier Modulator

This block produces the load-modulation switch signal with which a proximity contactless card answers a reader. It runs directly on the carrier clock. A divider chain derives two timings from that clock: a subcarrier at one sixteenth of the carrier (847.5 kHz at 13.56 MHz), and a bit period of eight subcarrier periods (about 105.93 kHz).

Each bit takes one data value from a selectable source. The source is either a steady stream of ones, an alternating one/zero pattern, or an external serial line that is synchronised to the carrier clock. The data is line-coded as NRZ or Manchester. The coded level then drives the subcarrier by on-off keying (ASK) or by binary phase-shift keying (BPSK). The registered result drives the switch of the load modulator.

Source, coding and modulation selections are plain control pins. Their values are captured only at bit boundaries. The external data line is likewise taken once per bit. There is no flow control: the block always transmits, and a producer on the external line must present each bit in time for its capture point.

Top module: `pcm_subcarrier_mod`

## Requirements
- R1: The subcarrier period is SUB_DIV carrier cycles, high for the first SUB_DIV/2 cycles of each period. Subcarrier periods start at reset release.
- R2: A bit lasts SUB_DIV*SUBS_PER_BIT carrier cycles. Bit n covers carrier cycles n*BIT_LEN to n*BIT_LEN+BIT_LEN-1, counted from reset release. mod_out is registered, so it shows the value for cycle c one clock later.
- R3: With ASK and NRZ, a 1 bit carries the subcarrier for its whole length and a 0 bit keeps mod_out low.
- R4: With ASK and Manchester, a 1 bit carries the subcarrier in its first SUBS_PER_BIT/2 subcarrier periods and a 0 bit in its second half. The other half stays low.
- R5: With BPSK, a coded level of 1 sends the subcarrier in phase and a level of 0 sends it inverted. Under NRZ the phase therefore flips exactly on a bit boundary where the data changes. Under Manchester the half-bit level selects the phase.
- R6: src_sel = 2'b00 gives a data value of 1 in every bit.
- R7: src_sel = 2'b01 gives an alternating pattern: data 1 in odd-numbered bits and 0 in even-numbered bits, counting from reset.
- R8: src_sel = 2'b10 or 2'b11 uses ext_data. The line passes two synchroniser flops, and the value taken for bit n is ext_data as sampled on the clock edge three cycles before the end of bit n-1.
- R9: Values of src_sel, code_manch (1 = Manchester, 0 = NRZ) and mod_bpsk (1 = BPSK, 0 = ASK) act only from the next bit boundary. They are captured on the last cycle of the current bit.
- R10: During reset and throughout bit 0, mod_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_sel | input | 2 | Data source: 00 ones, 01 alternating, 1x external |
| code_manch | input | 1 | Line code: 1 Manchester, 0 NRZ |
| mod_bpsk | input | 1 | Modulation: 1 BPSK, 0 ASK |
| ext_data | input | 1 | External serial data, asynchronous |
| mod_out | output | 1 | Load-modulation switch drive |

## Verification
The bench builds the block with SUB_DIV = 4 and SUBS_PER_BIT = 4, which gives 16-cycle bits in place of 128-cycle bits. That brings about sixty bits, with every source, coding and modulation pairing, into a short run. It also makes both Manchester halves and both subcarrier halves only a few cycles long, so any one-cycle slip in the divider or the capture point shows up as a mismatch. Selection changes land at offsets that are not multiples of the bit length, which exercises the boundary-only capture. External data changes every bit at varying phases, which exercises the synchroniser delay.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    SRC_ONES = 2'b00,
    SRC_ALT  = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_EXT2 = 2'b11
  } src_e;

  typedef struct packed {
    logic manch;
    logic bpsk;
  } line_cfg_t;

  localparam int SYNC_N = 2;
endpackage

// File: rtl/pcm_timebase.sv
module pcm_timebase #(
  parameter int SUB_DIV      = 16,
  parameter int SUBS_PER_BIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic sub_hi,
  output logic first_half,
  output logic bit_end
);
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam int IW = (SUBS_PER_BIT > 1) ? $clog2(SUBS_PER_BIT) : 1;

  logic [SW-1:0] sub_cnt;
  logic [IW-1:0] idx_cnt;
  logic sub_wrap, last_sub;

  assign sub_wrap = (sub_cnt == SW'(SUB_DIV - 1));
  assign last_sub = (idx_cnt == IW'(SUBS_PER_BIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      idx_cnt <= '0;
    end else begin
      sub_cnt <= sub_wrap ? '0 : sub_cnt + 1'b1;
      if (sub_wrap) idx_cnt <= last_sub ? '0 : idx_cnt + 1'b1;
    end
  end

  // high half of the subcarrier period, first half of the bit
  assign sub_hi     = (sub_cnt < SW'(SUB_DIV / 2));
  assign first_half = (idx_cnt < IW'(SUBS_PER_BIT / 2));
  assign bit_end    = sub_wrap & last_sub;
endmodule

// File: rtl/pcm_source.sv
module pcm_source
  import pcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_end,
  input  logic ext_data,
  output logic ext_sync,
  output logic alt_phase
);
  logic [SYNC_N-1:0] sync_q;

  // synchroniser chain, one stage per loop step
  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= ext_data;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
    end
  end

  assign ext_sync = sync_q[SYNC_N-1];

  // pattern phase advances once per bit
  always_ff @(posedge clk) begin
    if (!rst_n) alt_phase <= 1'b0;
    else if (bit_end) alt_phase <= ~alt_phase;
  end
endmodule

// File: rtl/pcm_modulator.sv
module pcm_modulator
  import pcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_end,
  input  logic      sub_hi,
  input  logic      first_half,
  input  src_e      src,
  input  line_cfg_t cfg,
  input  logic      ext_sync,
  input  logic      alt_phase,
  output logic      mod_out
);
  logic      next_bit, data_q, level, out_d;
  line_cfg_t cfg_q;

  always_comb begin
    unique case (src)
      SRC_ONES: next_bit = 1'b1;
      SRC_ALT:  next_bit = ~alt_phase;
      default:  next_bit = ext_sync;
    endcase
  end

  // data and line settings are taken only at the bit boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      cfg_q  <= '0;
    end else if (bit_end) begin
      data_q <= next_bit;
      cfg_q  <= cfg;
    end
  end

  always_comb begin
    if (cfg_q.manch) level = data_q ? first_half : ~first_half;
    else             level = data_q;
    if (cfg_q.bpsk)  out_d = ~(sub_hi ^ level);
    else             out_d = sub_hi & level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mod_out <= 1'b0;
    else        mod_out <= out_d;
  end
endmodule

// File: rtl/pcm_subcarrier_mod.sv
module pcm_subcarrier_mod
  import pcm_pkg::*;
#(
  parameter int SUB_DIV      = 16,
  parameter int SUBS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       code_manch,
  input  logic       mod_bpsk,
  input  logic       ext_data,
  output logic       mod_out
);
  logic      sub_hi, first_half, bit_end, ext_sync, alt_phase;
  line_cfg_t cfg;

  assign cfg = '{manch: code_manch, bpsk: mod_bpsk};

  pcm_timebase #(.SUB_DIV(SUB_DIV), .SUBS_PER_BIT(SUBS_PER_BIT)) u_tb (
    .clk(clk), .rst_n(rst_n), .sub_hi(sub_hi),
    .first_half(first_half), .bit_end(bit_end)
  );

  pcm_source u_src (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .ext_data(ext_data),
    .ext_sync(ext_sync), .alt_phase(alt_phase)
  );

  pcm_modulator u_mod (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .sub_hi(sub_hi),
    .first_half(first_half), .src(src_e'(src_sel)), .cfg(cfg),
    .ext_sync(ext_sync), .alt_phase(alt_phase), .mod_out(mod_out)
  );
endmodule

// File: rtl/pcm_sva.sv
module pcm_sva #(
  parameter int BIT_LEN = 128
) (
  input logic clk,
  input logic rst_n,
  input logic ext_data,
  input logic mod_out,
  input logic bit_end,
  input logic ext_sync,
  input logic alt_phase
);
  localparam int CW = $clog2(BIT_LEN) + 1;
  logic [CW-1:0] ref_cnt;
  logic [1:0]    warm;
  logic          first_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt    <= '0;
      warm       <= '0;
      first_done <= 1'b0;
    end else begin
      ref_cnt <= (ref_cnt == CW'(BIT_LEN - 1)) ? '0 : ref_cnt + 1'b1;
      if (warm != 2'd2) warm <= warm + 1'b1;
      if (bit_end) first_done <= 1'b1;
    end
  end

  p_bit_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end == (ref_cnt == CW'(BIT_LEN - 1)));

  p_ext_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (ext_sync == $past(ext_data, 2)));

  p_alt_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (alt_phase != $past(alt_phase)));

  p_alt_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(alt_phase));

  p_idle_first_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !first_done |-> !mod_out);
endmodule

bind pcm_subcarrier_mod pcm_sva #(.BIT_LEN(SUB_DIV * SUBS_PER_BIT)) u_sva (
  .clk(clk), .rst_n(rst_n), .ext_data(ext_data), .mod_out(mod_out),
  .bit_end(bit_end), .ext_sync(ext_sync), .alt_phase(alt_phase)
);

// File: tb/sim_pcm_subcarrier_mod.sv
module sim_pcm_subcarrier_mod;
  localparam int SD     = 4;
  localparam int SPB    = 4;
  localparam int BITLEN = SD * SPB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic       code_manch = 1'b0;
  logic       mod_bpsk = 1'b0;
  logic       ext_data = 1'b0;
  logic       mod_out;

  always #2 clk = ~clk;

  pcm_subcarrier_mod #(.SUB_DIV(SD), .SUBS_PER_BIT(SPB)) u0 (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .code_manch(code_manch),
    .mod_bpsk(mod_bpsk), .ext_data(ext_data), .mod_out(mod_out)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    running = 0;
  bit    done = 0;
  int    cyc = 0;
  logic  m_data = 0, m_manch = 0, m_bpsk = 0, ext_rec = 0;
  string m_tag = "R10";
  logic  q_val[$];
  string q_tag[$];

  // R1 subcarrier halves, R2 bit slots, R3/R4/R5 coding and modulation
  function automatic logic model_out(int p, logic d, logic m, logic b);
    logic sub, fh, lvl;
    sub = (p % SD) < (SD / 2);
    fh  = (p / SD) < (SPB / 2);
    lvl = m ? (d ? fh : !fh) : d;
    return b ? (sub == lvl) : (sub && lvl);
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: mod_out=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  // predictor and monitor
  always @(negedge clk) begin
    if (running) begin
      int p, nb;
      if (q_val.size() > 0) check(q_tag.pop_front(), mod_out, q_val.pop_front());
      p = cyc % BITLEN;
      q_val.push_back(model_out(p, m_data, m_manch, m_bpsk));
      q_tag.push_back(m_tag);
      if (p == BITLEN - 3) ext_rec = ext_data;        // R8 capture point
      if (p == BITLEN - 1) begin                       // R9 boundary capture
        nb = cyc / BITLEN + 1;
        case (src_sel)
          2'b00:   begin m_data = 1'b1;          m_tag = "R6"; end
          2'b01:   begin m_data = (nb % 2) == 1; m_tag = "R7"; end
          default: begin m_data = ext_rec;       m_tag = "R8"; end
        endcase
        m_manch = code_manch;
        m_bpsk  = mod_bpsk;
        m_tag = {m_tag, mod_bpsk ? "/R5" : (code_manch ? "/R4" : "/R3"), "/R9"};
      end
      cyc++;
    end
  end

  task automatic drive(logic [1:0] s, logic m, logic b, int cycles);
    src_sel = s; code_manch = m; mod_bpsk = b;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic drive_ext(logic m, logic b, int nbits, int offs);
    src_sel = 2'b10; code_manch = m; mod_bpsk = b;
    for (int i = 0; i < nbits; i++) begin
      ext_data = ((i * 5 + offs) % 3) == 0;
      repeat (BITLEN - 1 + (i % 3)) @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", mod_out, 1'b0);      // reset state
    rst_n = 1'b1;
    running = 1;
    drive(2'b00, 1'b0, 1'b0, 4 * BITLEN + 5);   // ones, ASK NRZ
    drive(2'b01, 1'b0, 1'b0, 4 * BITLEN + 3);   // alternating, ASK NRZ
    drive(2'b01, 1'b1, 1'b0, 4 * BITLEN + 7);   // alternating, Manchester ASK
    drive(2'b00, 1'b1, 1'b0, 3 * BITLEN + 2);   // ones, Manchester ASK
    drive(2'b01, 1'b0, 1'b1, 5 * BITLEN + 9);   // alternating, BPSK NRZ
    drive(2'b01, 1'b1, 1'b1, 4 * BITLEN + 1);   // alternating, BPSK Manchester
    drive(2'b00, 1'b0, 1'b1, 3 * BITLEN + 6);   // ones, BPSK NRZ
    // R9: selections toggled mid-bit for a few cycles only
    drive(2'b00, 1'b1, 1'b1, 5);
    drive(2'b01, 1'b0, 1'b0, BITLEN + 4);
    drive_ext(1'b0, 1'b0, 8, 1);                // external, ASK NRZ
    drive_ext(1'b1, 1'b0, 6, 2);                // external, Manchester ASK
    drive_ext(1'b0, 1'b1, 6, 0);                // external, BPSK NRZ
    drive_ext(1'b1, 1'b1, 6, 1);                // external, BPSK Manchester
    drive(2'b11, 1'b0, 1'b0, 2 * BITLEN);
    running = 0;
    done = 1;
    finish_run();
  end
endmodule